// File: doc/BRIEF.md
# Multi-Speed Serial Audio Output Port

This block takes up to four stereo PCM pairs and shifts them out as serial audio, one data line per pair. Each channel of a frame occupies a fixed slot, and the word select line marks the channel in that slot: low for left, high for right. In master mode the port makes its own bit clock and word select. The bit clock is divided down from `clk_i`, which is an oversampling clock running at twice the audio master clock. The audio master clock is 256 or 384 times the sample rate. In slave mode the port uses an external bit clock and word select, passes them straight to its outputs, and aligns its data to them.

Three speeds are supported. Single speed gives word select at 1fs and the bit clock at 64fs. Double speed gives 2fs and 128fs. Quad speed gives word select at 4fs, with the bit clock at 256fs or 192fs depending on the master clock ratio. In quad mode all pairs are time-multiplexed onto the first data line, one pair per word-select frame, and a frame-begin strobe marks each group of four frames so that several devices can be chained. Words can be sent in I2S framing or LSB-justified framing, at 16, 18 or 20 bits. Samples are supplied MSB-aligned in `MAX_W`-bit fields, and any bits below the selected length are dropped.

Top module: `serial_audio_out`

## Requirements
- R1: In master mode, `bck_o` is a square wave whose high and low phases each last H cycles of `clk_i`. H is 4, 2 or 1 with `mclk384_i`=0, and 6, 3 or 2 with `mclk384_i`=1, for single, double and quad speed respectively. `speed_i` encodes 0 as single, 1 as double, and 2 or 3 as quad.
- R2: Each channel slot lasts 32 bit-clock periods. The one exception is quad speed with `mclk384_i`=1, where a slot lasts 24. `ws_o` is low for the left slot and high for the right slot.
- R3: In I2S framing (`lsbj_i`=0), the first bit period after a word-select change carries a zero. The next W periods carry the word MSB first, and the rest of the slot is zero. `wlen_i` encodes 0 as W=16, 1 as W=18, and 2 or 3 as W=20. The word is the top W bits of the MAX_W-bit sample.
- R4: In LSB-justified framing (`lsbj_i`=1), the word occupies the last W bit periods of the slot, MSB first, and all earlier bits of the slot are zero.
- R5: At quad speed, framing is always I2S whatever `lsbj_i` says. Frame k of each group of four carries pair k on `sd_o[0]`, and every other data line stays zero.
- R6: At quad speed, `sdb_o` is high during frames 0 and 1 of each group and low during frames 2 and 3, so it rises when the left slot of frame 0 begins. Outside quad speed it stays low.
- R7: In slave mode, `bck_o` equals `bck_i` and `ws_o` equals `ws_i`. A slot starts at the first falling edge of `bck_i` after a change of `ws_i`.
- R8: In master mode, `sd_o` and `ws_o` change only in the cycle where `bck_o` falls.
- R9: While `rst_ni` is low, `bck_o`, `sd_o` and `sdb_o` are 0 and `ws_o` is 1 in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, twice the audio master clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: generate bit clock and word select; 0: follow external |
| mclk384_i | input | 1 | Master clock ratio: 0 = 256fs, 1 = 384fs |
| speed_i | input | 2 | 0 single, 1 double, 2/3 quad |
| lsbj_i | input | 1 | 0 I2S framing, 1 LSB-justified framing |
| wlen_i | input | 2 | Word length select: 0 = 16, 1 = 18, 2/3 = 20 |
| bck_i | input | 1 | External bit clock (slave mode) |
| ws_i | input | 1 | External word select (slave mode) |
| pcm_i | input | NUM_PAIRS*2*MAX_W | Samples; word 2p is pair p left, 2p+1 is pair p right |
| bck_o | output | 1 | Bit clock out |
| ws_o | output | 1 | Word select out |
| sd_o | output | NUM_PAIRS | Serial data, one line per pair |
| sdb_o | output | 1 | Quad-mode frame-begin strobe |

## Verification
The bench builds the port with its defaults, NUM_PAIRS=4 and MAX_W=20. With these values quad mode fills all four frames of a group with real pairs, and the 20-bit word length can be exercised at full width. Because the sample fields are 20 bits wide, the dropped low bits at 16 and 18 bits are non-zero in the stimulus, so any leak of those bits would show up on the data lines. The combinations run cover both master clock ratios at each speed, the 24-bit slot of quad speed at 384fs, and a slave run driven by an external bit clock that is slower than any ratio the port generates itself.

// File: rtl/sao_pkg.sv
package sao_pkg;
  localparam int SLOT_STD  = 32;
  localparam int SLOT_Q384 = 24;

  // bit-clock half period in clk_i cycles (clk_i = 2x master clock)
  function automatic logic [2:0] bck_half(input logic sel384, input logic [1:0] spd);
    if (spd[1])      return sel384 ? 3'd2 : 3'd1;
    else if (spd[0]) return sel384 ? 3'd3 : 3'd2;
    else             return sel384 ? 3'd6 : 3'd4;
  endfunction

  function automatic logic [5:0] slot_bits(input logic sel384, input logic [1:0] spd);
    return (spd[1] && sel384) ? 6'(SLOT_Q384) : 6'(SLOT_STD);
  endfunction

  function automatic logic [4:0] word_bits(input logic [1:0] wl);
    case (wl)
      2'd0:    return 5'd16;
      2'd1:    return 5'd18;
      default: return 5'd20;
    endcase
  endfunction
endpackage

// File: rtl/sao_bclk_gen.sv
module sao_bclk_gen (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] half_i,
  output logic       bck_o,
  output logic       fall_o
);
  logic [2:0] cnt_q;
  logic       bck_q;
  logic       term;

  assign term   = (cnt_q == half_i - 3'd1);
  assign fall_o = en_i && term && bck_q;
  assign bck_o  = bck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      bck_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      bck_q <= ~bck_q;
    end else begin
      cnt_q <= cnt_q + 3'd1;
    end
  end

  // a phase of two or more cycles never toggles on consecutive edges
  assert_min_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && half_i >= 3'd2 && !$stable(bck_q) |=> $stable(bck_q));
endmodule

// File: rtl/sao_slave_sync.sv
module sao_slave_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bck_i,
  input  logic ws_i,
  output logic fall_o,
  output logic ws_o
);
  logic b_meta, b_sync, b_prev, w_meta, w_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_meta <= 1'b0;
      b_sync <= 1'b0;
      b_prev <= 1'b0;
      w_meta <= 1'b1;
      w_sync <= 1'b1;
    end else begin
      b_meta <= bck_i;
      b_sync <= b_meta;
      b_prev <= b_sync;
      w_meta <= ws_i;
      w_sync <= w_meta;
    end
  end

  assign fall_o = b_prev && !b_sync;
  assign ws_o   = w_sync;
endmodule

// File: rtl/sao_frame_ser.sv
module sao_frame_ser #(
  parameter  int NUM_PAIRS = 4,
  parameter  int MAX_W     = 20,
  localparam int PW        = NUM_PAIRS * 2 * MAX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 master_i,
  input  logic                 ext_ws_i,
  input  logic                 quad_i,
  input  logic                 lsbj_i,
  input  logic [4:0]           wbits_i,
  input  logic [5:0]           slot_i,
  input  logic [PW-1:0]        pcm_i,
  output logic                 ws_o,
  output logic [NUM_PAIRS-1:0] sd_o,
  output logic                 sdb_o
);
  logic [4:0]           cnt_q, cnt_n;
  logic                 ws_q, ws_n;
  logic [1:0]           grp_q, grp_n;
  logic                 left_start, load;
  logic [PW-1:0]        hold_q;
  logic [NUM_PAIRS-1:0] sd_q, lane_bit;
  logic                 sdb_q;
  logic                 in_word;
  logic [5:0]           pos, lead;

  always_comb begin
    if (master_i) begin
      if ({1'b0, cnt_q} >= slot_i - 6'd1) begin
        cnt_n = '0;
        ws_n  = ~ws_q;
      end else begin
        cnt_n = cnt_q + 5'd1;
        ws_n  = ws_q;
      end
    end else if (ext_ws_i != ws_q) begin
      cnt_n = '0;
      ws_n  = ext_ws_i;
    end else begin
      cnt_n = (&cnt_q) ? cnt_q : cnt_q + 5'd1;
      ws_n  = ws_q;
    end
    left_start = ws_q && !ws_n;
    grp_n      = left_start ? grp_q + 2'd1 : grp_q;
    load       = left_start && (!quad_i || grp_n == 2'd0);
    lead       = slot_i - {1'b0, wbits_i};
    if (lsbj_i) begin
      in_word = {1'b0, cnt_n} >= lead;
      pos     = {1'b0, cnt_n} - lead;
    end else begin
      in_word = (cnt_n != 5'd0) && (cnt_n <= wbits_i);
      pos     = {1'b0, cnt_n} - 6'd1;
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_lane
    logic [MAX_W-1:0] word, word_sh;
    logic             active;
    int               src;
    assign src     = quad_i ? (int'(grp_n) % NUM_PAIRS) : p;
    assign active  = quad_i ? ((p == 0) && (int'(grp_n) < NUM_PAIRS)) : 1'b1;
    assign word    = hold_q[(2 * src + int'(ws_n)) * MAX_W +: MAX_W];
    assign word_sh = word << pos;
    assign lane_bit[p] = active && in_word && word_sh[MAX_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= 5'd31;
      ws_q   <= 1'b1;
      grp_q  <= 2'd3;
      hold_q <= '0;
      sd_q   <= '0;
      sdb_q  <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_n;
      ws_q  <= ws_n;
      grp_q <= grp_n;
      sd_q  <= lane_bit;
      sdb_q <= quad_i && !grp_n[1];
      if (load) hold_q <= pcm_i;
    end
  end

  assign ws_o  = ws_q;
  assign sd_o  = sd_q;
  assign sdb_o = sdb_q;

  assert_slot_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && tick_i |=> {1'b0, cnt_q} < slot_i);
  assert_ws_at_slot0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && !$stable(ws_q) |-> cnt_q == 5'd0);
  assert_strobe_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdb_q) |-> $fell(ws_q));
  assert_quad_lanes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_i |-> (sd_q >> 1) == '0);
endmodule

// File: rtl/serial_audio_out.sv
module serial_audio_out import sao_pkg::*; #(
  parameter  int NUM_PAIRS = 4,
  parameter  int MAX_W     = 20,
  localparam int PW        = NUM_PAIRS * 2 * MAX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 master_i,
  input  logic                 mclk384_i,
  input  logic [1:0]           speed_i,
  input  logic                 lsbj_i,
  input  logic [1:0]           wlen_i,
  input  logic                 bck_i,
  input  logic                 ws_i,
  input  logic [PW-1:0]        pcm_i,
  output logic                 bck_o,
  output logic                 ws_o,
  output logic [NUM_PAIRS-1:0] sd_o,
  output logic                 sdb_o
);
  logic gen_bck, gen_fall, ext_fall, ext_ws, tick, quad, eng_ws;

  assign quad = speed_i[1];
  assign tick = master_i ? gen_fall : ext_fall;

  sao_bclk_gen u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (master_i),
    .half_i (bck_half(mclk384_i, speed_i)),
    .bck_o  (gen_bck),
    .fall_o (gen_fall)
  );

  sao_slave_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bck_i  (bck_i),
    .ws_i   (ws_i),
    .fall_o (ext_fall),
    .ws_o   (ext_ws)
  );

  sao_frame_ser #(.NUM_PAIRS(NUM_PAIRS), .MAX_W(MAX_W)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .master_i (master_i),
    .ext_ws_i (ext_ws),
    .quad_i   (quad),
    .lsbj_i   (lsbj_i && !quad),
    .wbits_i  (word_bits(wlen_i)),
    .slot_i   (slot_bits(mclk384_i, speed_i)),
    .pcm_i    (pcm_i),
    .ws_o     (eng_ws),
    .sd_o     (sd_o),
    .sdb_o    (sdb_o)
  );

  assign bck_o = master_i ? gen_bck : bck_i;
  assign ws_o  = master_i ? eng_ws : ws_i;

  assert_data_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && (!$stable(sd_o) || !$stable(ws_o)) |-> $fell(bck_o));
endmodule

// File: tb/serial_audio_out_test.sv
module serial_audio_out_test;
  localparam int NP = 4;
  localparam int MW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b1, m384 = 1'b0, lsbj = 1'b0, bck_in = 1'b1, ws_in = 1'b1;
  logic [1:0] spd = 2'd0, wl = 2'd2;
  logic [NP*2*MW-1:0] pcm;
  logic [MW-1:0] smp [NP*2];
  logic bck_o, ws_o, sdb_o;
  logic [NP-1:0] sd_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_audio_out #(.NUM_PAIRS(NP), .MAX_W(MW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .mclk384_i(m384),
    .speed_i(spd), .lsbj_i(lsbj), .wlen_i(wl), .bck_i(bck_in), .ws_i(ws_in),
    .pcm_i(pcm), .bck_o(bck_o), .ws_o(ws_o), .sd_o(sd_o), .sdb_o(sdb_o));

  always_comb
    for (int j = 0; j < NP*2; j++) pcm[j*MW +: MW] = smp[j];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [MW-1:0] s, input bit lj, input int w,
                                   input int slot, input int k);
    if (lj) return (k >= slot - w) ? s[MW-1-(k-(slot-w))] : 1'b0;
    return (k >= 1 && k <= w) ? s[MW-k] : 1'b0;
  endfunction

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 18 : 20;
  endfunction

  task automatic fill(input logic [MW-1:0] seed);
    for (int j = 0; j < NP*2; j++) smp[j] = seed ^ MW'(j * 20'h1357B) ^ MW'(20'hA5C3F);
  endtask

  task automatic do_reset(input bit ms, input bit s384, input logic [1:0] sp,
                          input bit lj, input logic [1:0] w);
    @(negedge clk);
    rst_n = 1'b0; master = ms; m384 = s384; spd = sp; lsbj = lj; wl = w;
    bck_in = 1'b1; ws_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_reset();
    do_reset(1, 0, 2'd2, 0, 2'd2);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(bck_o == 1'b0, "R9 bck_o in reset", bck_o, 0);
    chk(sd_o == '0, "R9 sd_o in reset", sd_o, 0);
    chk(sdb_o == 1'b0, "R9 sdb_o in reset", sdb_o, 0);
    chk(ws_o == 1'b1, "R9 ws_o in reset", ws_o, 1);
  endtask

  task automatic measure_half(input int h);
    int n = 0;
    bit pb = 1'b1;
    @(posedge bck_o);
    @(negedge clk);
    forever begin
      @(negedge clk);
      n++;
      if (bck_o && !pb) break;
      pb = bck_o;
    end
    chk(n == 2*h, "R1 bit clock period", n, 2*h);
  endtask

  // single or double speed, master mode
  task automatic test_master(input bit s384, input logic [1:0] sp, input bit lj,
                             input logic [1:0] w, input int h, input logic [MW-1:0] seed);
    int err [NP];
    int ws_err = 0;
    bit prev;
    fill(seed);
    do_reset(1, s384, sp, lj, w);
    measure_half(h);
    prev = ws_o;
    forever begin
      @(posedge bck_o); #1;
      if (prev && !ws_o) break;
      prev = ws_o;
    end
    for (int p = 0; p < NP; p++) err[p] = 0;
    for (int k = 0; k <= 64; k++) begin
      if (k > 0) begin @(posedge bck_o); #1; end
      if (k == 64) begin
        if (ws_o !== 1'b0) ws_err++;
      end else begin
        if (ws_o !== logic'(k >= 32)) ws_err++;
        for (int p = 0; p < NP; p++)
          if (sd_o[p] !== exp_bit(smp[2*p + k/32], lj, wbits(w), 32, k % 32)) err[p]++;
      end
    end
    chk(ws_err == 0, "R2 word select slot", ws_err, 0);
    for (int p = 0; p < NP; p++)
      chk(err[p] == 0, lj ? "R4 lsb-justified lane" : "R3 i2s lane", err[p], 0);
  endtask

  task automatic test_quad(input bit s384, input bit lj_req, input logic [1:0] w,
                           input int h, input logic [MW-1:0] seed);
    int slot = s384 ? 24 : 32;
    int d_err = 0, z_err = 0, s_err = 0, ws_err = 0;
    bit prev_s;
    fill(seed);
    do_reset(1, s384, 2'd2, lj_req, w);
    measure_half(h);
    prev_s = sdb_o;
    forever begin
      @(posedge bck_o); #1;
      if (!prev_s && sdb_o) break;
      prev_s = sdb_o;
    end
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < 2*slot; k++) begin
        if (f > 0 || k > 0) begin @(posedge bck_o); #1; end
        if (ws_o !== logic'(k >= slot)) ws_err++;
        if (sdb_o !== logic'(f < 2)) s_err++;
        if ((sd_o >> 1) != '0) z_err++;
        if (sd_o[0] !== exp_bit(smp[2*f + k/slot], 1'b0, wbits(w), slot, k % slot)) d_err++;
      end
    chk(ws_err == 0, "R2 quad slot length", ws_err, 0);
    chk(d_err == 0, "R5 quad multiplexed i2s data", d_err, 0);
    chk(z_err == 0, "R5 quad idle lanes zero", z_err, 0);
    chk(s_err == 0, "R6 frame-begin strobe", s_err, 0);
  endtask

  task automatic test_slave(input logic [1:0] w, input logic [MW-1:0] seed);
    int err [NP];
    int pass_err = 0, sdb_err = 0;
    fill(seed);
    do_reset(0, 0, 2'd0, 0, w);
    for (int p = 0; p < NP; p++) err[p] = 0;
    repeat (4) @(negedge clk);
    for (int f = 0; f < 3; f++)
      for (int k = 0; k < 64; k++) begin
        bck_in = 1'b0; ws_in = (k >= 32);
        #1;
        if (bck_o !== bck_in || ws_o !== ws_in) pass_err++;
        repeat (8) @(negedge clk);
        bck_in = 1'b1;
        #1;
        if (bck_o !== bck_in || ws_o !== ws_in) pass_err++;
        if (sdb_o !== 1'b0) sdb_err++;
        for (int p = 0; p < NP; p++)
          if (sd_o[p] !== exp_bit(smp[2*p + k/32], 1'b0, wbits(w), 32, k % 32)) err[p]++;
        repeat (8) @(negedge clk);
      end
    chk(pass_err == 0, "R7 slave clock passthrough", pass_err, 0);
    chk(sdb_err == 0, "R6 strobe low outside quad", sdb_err, 0);
    for (int p = 0; p < NP; p++)
      chk(err[p] == 0, "R7 slave-aligned data", err[p], 0);
  endtask

  task automatic test_data_edge();
    int bad = 0;
    logic [NP-1:0] psd;
    logic pws, pbck;
    do_reset(1, 1, 2'd0, 0, 2'd1);
    @(negedge clk);
    psd = sd_o; pws = ws_o; pbck = bck_o;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if ((sd_o != psd || ws_o != pws) && !(pbck && !bck_o)) bad++;
      psd = sd_o; pws = ws_o; pbck = bck_o;
    end
    chk(bad == 0, "R8 changes only on bit clock fall", bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    if (!done) begin
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    fill(20'h0);
    test_reset();
    test_master(0, 2'd0, 0, 2'd2, 4, 20'h3C1E7);  // 256fs single, I2S 20
    test_master(1, 2'd0, 1, 2'd0, 6, 20'h51A0D);  // 384fs single, LSBJ 16
    test_master(0, 2'd1, 0, 2'd1, 2, 20'h0F3B9);  // 256fs double, I2S 18
    test_master(1, 2'd1, 1, 2'd2, 3, 20'h7E655);  // 384fs double, LSBJ 20
    test_quad(0, 0, 2'd2, 1, 20'h2D4C3);          // 256fs quad
    test_quad(1, 1, 2'd0, 2, 20'h69A17);          // 384fs quad, LSBJ request forced to I2S
    test_slave(2'd0, 20'h13F5B);
    test_data_edge();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule